// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Sequencer

This block drives the control side of an EDO or fast-page DRAM array made of two banks. It takes one request at a time, made up of a bank, a row, one or two column addresses, a direction and write data. It then produces the row strobe for the selected bank, the column strobe, write enable, output enable and a 9-bit multiplexed address. Timing comes from programmable interval settings in units of half a memory clock. The block therefore runs on a clock at twice the memory clock rate, and one clock of the block is called a tick below.

A request is either a single access or a pair of accesses in opposite directions to the same open row. A pair is read-then-write or write-then-read, and the column strobe is high for a programmable turnaround between the two accesses. Read data is captured at one of four selectable edges after the column strobe rises. One 2-bit selector serves coprocessor reads and a second serves all other reads. The block raises `done` for one memory clock when the row strobe rises and returns to idle afterwards.

Top module: `dram_edo_seq`

## Requirements
- R1: While reset is held and afterwards until a request arrives, both row strobes, the column strobe, write enable and output enable are high, `done` is low, `req_ready` is high and the address is zero.
- R2: Each setting is clamped to its legal range in ticks: precharge and row-active width 5 to 8, column pulse 1 to 2, column precharge 2 to 3, and both turnarounds 2 to 6. A raw value below the range acts as its minimum and a raw value above it acts as its maximum.
- R3: The row strobe of bank `req_bank` (index 0 or 1) stays high for the precharge count P of ticks after acceptance while the row is driven on the address. The strobe of the other bank stays high for the whole request.
- R4: The row stays on the address for 2 ticks after the row strobe falls and the column follows. The column strobe falls 4 ticks after the row strobe falls and stays low for the column-pulse count.
- R5: For a write, write enable goes low one tick before the column strobe falls and rises with it, and the data output enable equals write enable with `req_wdata` driven. For a read, output enable goes low 2 ticks after the row strobe falls and rises with the column strobe.
- R6: `req_op` is encoded as 0 single read, 1 single write, 2 read then write, 3 write then read. For a pair, the column strobe stays high for the read-to-write turnaround (op 2) or the write-to-read turnaround (op 3), and `req_col_b` is on the address from the start of that gap. The second access follows R5, except that a second read has output enable low for the whole gap.
- R7: The row strobe rises at the latest of three points: the column-precharge count after the last column strobe rises, the row-active count after the row strobe fell, and the read capture edge. `done` is high for exactly 2 ticks starting there, and `req_ready` returns one tick after that.
- R8: With selector value s (0 to 3), read data on `dram_dq_in` is captured at the clock edge s ticks after the read column strobe rises. Value 0 is the rising edge itself. `req_cop`=1 selects `cfg_lat_cop`, otherwise `cfg_lat_gen` is used.
- R9: A write leaves `rd_data` unchanged, and write enable and output enable are never low together.
- R10: `req_valid` is ignored while `req_ready` is low, and changes to the settings after acceptance do not affect the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rp | input | 4 | Row precharge ticks |
| cfg_ras | input | 4 | Minimum row-active ticks |
| cfg_cas | input | 4 | Column pulse ticks |
| cfg_cp | input | 4 | Column precharge ticks before row close |
| cfg_rtw | input | 4 | Read-to-write turnaround ticks |
| cfg_wtr | input | 4 | Write-to-read turnaround ticks |
| cfg_lat_cop | input | 2 | Capture edge for coprocessor reads |
| cfg_lat_gen | input | 2 | Capture edge for other reads |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 2 | Access kind (see R6) |
| req_bank | input | 1 | Bank select |
| req_cop | input | 1 | Read belongs to the coprocessor |
| req_row | input | 9 | Row address |
| req_col_a | input | 9 | First column |
| req_col_b | input | 9 | Second column of a pair |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Last captured read data |
| done | output | 1 | Request finished |
| dram_ras_n | output | 2 | Row strobes, one per bank |
| dram_cas_n | output | 1 | Column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 9 | Multiplexed address |
| dram_dq_in | input | 32 | Data from the DRAM |
| dram_dq_out | output | 32 | Data to the DRAM |
| dram_dq_oe | output | 1 | Data driver enable |

## Verification
The hardest case to reach is the one where the read capture edge, and not the column precharge or the row-active minimum, decides when the row strobe rises. This needs a late selector, a short column precharge and a read as the last access. The stimulus builds it with a coprocessor read that uses selector 3 and the minimum precharge, and it also covers the row-active minimum as the deciding point with a long active width. A new pseudo-random value is driven on `dram_dq_in` every tick, so a capture one edge early or late returns a different word. During every request the bench also raises a stray `req_valid` and scrambles all settings, so that any sensitivity to them shows up in the per-tick comparison.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int TW = 4;
  localparam int LW = 2;
  localparam int ROWA_TICKS = 4;
  localparam int ROW_HOLD = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ROWA, ST_CASL, ST_GAP, ST_TAIL, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_RD = 2'd0, OP_WR = 2'd1, OP_RD_WR = 2'd2, OP_WR_RD = 2'd3
  } seq_op_e;

  typedef struct packed {
    logic [TW-1:0] rp;
    logic [TW-1:0] ras;
    logic [TW-1:0] cas;
    logic [TW-1:0] cp;
    logic [TW-1:0] rtw;
    logic [TW-1:0] wtr;
  } seq_timing_t;

  localparam int NFIELD = 6;
endpackage

// File: rtl/dram_cfg_clamp.sv
module dram_cfg_clamp #(
  parameter int W  = 4,
  parameter int LO = 1,
  parameter int HI = 8
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    if (raw < LO_V)      val = LO_V;
    else if (raw > HI_V) val = HI_V;
    else                 val = raw;
  end
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [LW-1:0] sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata,
  output logic          cap_ok
);
  logic          pend_q, pend_d;
  logic [LW-1:0] left_q, left_d;
  logic          cap_en;

  always_comb begin
    pend_d = pend_q;
    left_d = left_q;
    cap_en = 1'b0;
    if (arm) begin
      if (sel == '0) begin
        cap_en = 1'b1;
      end else begin
        pend_d = 1'b1;
        left_d = sel - LW'(1);
      end
    end else if (pend_q) begin
      if (left_q == '0) begin
        cap_en = 1'b1;
        pend_d = 1'b0;
      end else begin
        left_d = left_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      pend_q <= pend_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= din;
  end

  assign cap_ok = !pend_q || (left_q == '0);

  // R8
  cap_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !pend_q);
  // R8
  cap_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && left_q == '0) |=> !pend_q);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32,
  parameter int NB = 2,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [BW-1:0] req_bank,
  input  logic          req_cop,
  input  logic [AW-1:0] req_row,
  input  logic [AW-1:0] req_col_a,
  input  logic [AW-1:0] req_col_b,
  input  logic [DW-1:0] req_wdata,
  input  seq_timing_t   tim,
  input  logic [LW-1:0] lat_cop,
  input  logic [LW-1:0] lat_gen,
  input  logic          cap_ok,
  output logic          cap_arm,
  output logic [LW-1:0] cap_sel,
  output logic          done,
  output logic [NB-1:0] ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int RW = TW + 1;

  seq_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          second_q, second_d;
  seq_op_e       op_q;
  logic [BW-1:0] bank_q;
  logic [AW-1:0] row_q, cola_q, colb_q;
  logic [DW-1:0] wdata_q;
  seq_timing_t   tim_q;
  logic [LW-1:0] sel_q;

  logic          accept, first_wr, is_pair, cur_wr, ras_low;
  logic          we_lo, oe_lo;
  logic [AW-1:0] cur_col;
  logic [TW-1:0] gap_len;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign first_wr = (op_q == OP_WR) || (op_q == OP_WR_RD);
  assign is_pair  = (op_q == OP_RD_WR) || (op_q == OP_WR_RD);
  assign cur_wr   = second_q ? !first_wr : first_wr;
  assign cur_col  = second_q ? colb_q : cola_q;
  assign gap_len  = cur_wr ? tim_q.rtw : tim_q.wtr;
  assign ras_low  = (state_q == ST_ROWA) || (state_q == ST_CASL) ||
                    (state_q == ST_GAP)  || (state_q == ST_TAIL);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q + TW'(1);
    second_d = second_q;
    cap_arm  = 1'b0;
    rcnt_d   = (ras_low && rcnt_q != '1) ? rcnt_q + RW'(1) : rcnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          state_d  = ST_PRE;
          second_d = 1'b0;
        end
      end
      ST_PRE: begin
        if (cnt_q == tim_q.rp - TW'(1)) begin
          state_d = ST_ROWA;
          cnt_d   = '0;
          rcnt_d  = '0;
        end
      end
      ST_ROWA: begin
        if (cnt_q == TW'(ROWA_TICKS - 1)) begin
          state_d = ST_CASL;
          cnt_d   = '0;
        end
      end
      ST_CASL: begin
        if (cnt_q == tim_q.cas - TW'(1)) begin
          cnt_d   = '0;
          cap_arm = !cur_wr;
          if (is_pair && !second_q) begin
            state_d  = ST_GAP;
            second_d = 1'b1;
          end else begin
            state_d = ST_TAIL;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == gap_len - TW'(1)) begin
          state_d = ST_CASL;
          cnt_d   = '0;
        end
      end
      ST_TAIL: begin
        if ((cnt_q + TW'(1) >= tim_q.cp) &&
            (rcnt_q + RW'(1) >= {1'b0, tim_q.ras}) && cap_ok) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end
      end
      ST_DONE: begin
        if (cnt_q == TW'(1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rcnt_q   <= '0;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rcnt_q   <= rcnt_d;
      second_q <= second_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_RD;
      bank_q  <= '0;
      row_q   <= '0;
      cola_q  <= '0;
      colb_q  <= '0;
      wdata_q <= '0;
      tim_q   <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      op_q    <= seq_op_e'(req_op);
      bank_q  <= req_bank;
      row_q   <= req_row;
      cola_q  <= req_col_a;
      colb_q  <= req_col_b;
      wdata_q <= req_wdata;
      tim_q   <= tim;
      sel_q   <= req_cop ? lat_cop : lat_gen;
    end
  end

  always_comb begin
    we_lo = 1'b0;
    oe_lo = 1'b0;
    addr  = '0;
    case (state_q)
      ST_PRE:  addr = row_q;
      ST_ROWA: begin
        addr  = (cnt_q < TW'(ROW_HOLD)) ? row_q : cola_q;
        we_lo = cur_wr && (cnt_q == TW'(ROWA_TICKS - 1));
        oe_lo = !cur_wr && (cnt_q >= TW'(ROW_HOLD));
      end
      ST_CASL: begin
        addr  = cur_col;
        we_lo = cur_wr;
        oe_lo = !cur_wr;
      end
      ST_GAP: begin
        addr  = cur_col;
        we_lo = cur_wr && (cnt_q == gap_len - TW'(1));
        oe_lo = !cur_wr;
      end
      ST_TAIL: addr = cur_col;
      default: addr = '0;
    endcase
  end

  assign ras_n     = ras_low ? ~(NB'(1) << bank_q) : '1;
  assign cas_n     = (state_q != ST_CASL);
  assign we_n      = !we_lo;
  assign oe_n      = !oe_lo;
  assign dq_oe     = we_lo;
  assign dq_out    = wdata_q;
  assign done      = (state_q == ST_DONE);
  assign req_ready = (state_q == ST_IDLE);
  assign cap_sel   = sel_q;

  // R3
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n) <= 1);
  // R4
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (ras_n != '1));
  // R5
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> !$past(we_n));
  // R9
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> done);
  // R7
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |=> !done);
  // R7
  done_rows_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ras_n == '1));
  // R10
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && $past(state_q) != ST_PRE) |-> $past(state_q) == ST_IDLE);
endmodule

// File: rtl/dram_edo_seq.sv
module dram_edo_seq
  import dram_seq_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 32,
  parameter int NB = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TW-1:0]         cfg_rp,
  input  logic [TW-1:0]         cfg_ras,
  input  logic [TW-1:0]         cfg_cas,
  input  logic [TW-1:0]         cfg_cp,
  input  logic [TW-1:0]         cfg_rtw,
  input  logic [TW-1:0]         cfg_wtr,
  input  logic [LW-1:0]         cfg_lat_cop,
  input  logic [LW-1:0]         cfg_lat_gen,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_op,
  input  logic [$clog2(NB)-1:0] req_bank,
  input  logic                  req_cop,
  input  logic [AW-1:0]         req_row,
  input  logic [AW-1:0]         req_col_a,
  input  logic [AW-1:0]         req_col_b,
  input  logic [DW-1:0]         req_wdata,
  output logic [DW-1:0]         rd_data,
  output logic                  done,
  output logic [NB-1:0]         dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic                  dram_oe_n,
  output logic [AW-1:0]         dram_addr,
  input  logic [DW-1:0]         dram_dq_in,
  output logic [DW-1:0]         dram_dq_out,
  output logic                  dram_dq_oe
);
  function automatic int lo_of(int i);
    case (i)
      5, 4:    return 5;
      3:       return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int hi_of(int i);
    case (i)
      5, 4:    return 8;
      3:       return 2;
      2:       return 3;
      default: return 6;
    endcase
  endfunction

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic [NFIELD-1:0][TW-1:0] raw_f, lim_f;
  seq_timing_t               tim;

  assign raw_f = {cfg_rp, cfg_ras, cfg_cas, cfg_cp, cfg_rtw, cfg_wtr};

  for (genvar g = 0; g < NFIELD; g++) begin : g_clamp
    dram_cfg_clamp #(.W(TW), .LO(lo_of(g)), .HI(hi_of(g))) u_clamp (
      .raw (raw_f[g]),
      .val (lim_f[g])
    );
  end
  assign tim = seq_timing_t'(lim_f);

  logic          cap_arm, cap_ok;
  logic [LW-1:0] cap_sel;

  dram_seq_fsm #(.AW(AW), .DW(DW), .NB(NB)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_bank  (req_bank),
    .req_cop   (req_cop),
    .req_row   (req_row),
    .req_col_a (req_col_a),
    .req_col_b (req_col_b),
    .req_wdata (req_wdata),
    .tim       (tim),
    .lat_cop   (cfg_lat_cop),
    .lat_gen   (cfg_lat_gen),
    .cap_ok    (cap_ok),
    .cap_arm   (cap_arm),
    .cap_sel   (cap_sel),
    .done      (done),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe)
  );

  dram_rd_capture #(.DW(DW), .LW(LW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .arm    (cap_arm),
    .sel    (cap_sel),
    .din    (dram_dq_in),
    .rdata  (rd_data),
    .cap_ok (cap_ok)
  );
endmodule

// File: tb/sim_dram_edo_seq.sv
module sim_dram_edo_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [3:0]  cfg_rp, cfg_ras, cfg_cas, cfg_cp, cfg_rtw, cfg_wtr;
  logic [1:0]  cfg_lat_cop, cfg_lat_gen;
  logic        req_valid, req_ready, req_bank, req_cop;
  logic [1:0]  req_op;
  logic [8:0]  req_row, req_col_a, req_col_b, dram_addr;
  logic [31:0] req_wdata, rd_data, dram_dq_in, dram_dq_out;
  logic        done, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [1:0]  dram_ras_n;

  dram_edo_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_rp(cfg_rp), .cfg_ras(cfg_ras), .cfg_cas(cfg_cas), .cfg_cp(cfg_cp),
    .cfg_rtw(cfg_rtw), .cfg_wtr(cfg_wtr),
    .cfg_lat_cop(cfg_lat_cop), .cfg_lat_gen(cfg_lat_gen),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_cop(req_cop), .req_row(req_row),
    .req_col_a(req_col_a), .req_col_b(req_col_b), .req_wdata(req_wdata),
    .rd_data(rd_data), .done(done), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_in(dram_dq_in),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int          vecs = 0;
  int          bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] prev_rd = '0;
  logic [31:0] dval [64];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int max3(int a, int b, int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  task automatic set_cfg(int rp, int ras, int cas, int cp, int rtw, int wtr, int lc, int lg);
    cfg_rp = 4'(rp); cfg_ras = 4'(ras); cfg_cas = 4'(cas); cfg_cp = 4'(cp);
    cfg_rtw = 4'(rtw); cfg_wtr = 4'(wtr); cfg_lat_cop = 2'(lc); cfg_lat_gen = 2'(lg);
  endtask

  // Behavioural per-tick model of one request, compared on every tick.
  task automatic run(int op, int bank, int cop, logic [8:0] row, logic [8:0] ca,
                     logic [8:0] cb, logic [31:0] wd, string tag);
    int P, A, C, Q, G, s, c1, r1, c2, r2, L, R, tend;
    bit pair, fwr, swr, has_rd;
    logic [3:0] sv [6];
    logic [1:0] sl [2];
    logic [1:0]  e_ras;
    logic [8:0]  e_addr;
    bit e_cas, e_we, e_oe, e_done;
    logic [31:0] e_rd;
    P = clampi(int'(cfg_rp), 5, 8);  A = clampi(int'(cfg_ras), 5, 8);
    C = clampi(int'(cfg_cas), 1, 2); Q = clampi(int'(cfg_cp), 2, 3);
    pair = (op >= 2); fwr = (op == 1 || op == 3); swr = !fwr; has_rd = (op != 1);
    G = swr ? clampi(int'(cfg_rtw), 2, 6) : clampi(int'(cfg_wtr), 2, 6);
    s = cop ? int'(cfg_lat_cop) : int'(cfg_lat_gen);
    c1 = P + 4; r1 = c1 + C; c2 = r1 + G; r2 = c2 + C;
    L = pair ? r2 : r1;
    R = (op == 3) ? r2 : r1;
    tend = max3(L + Q, P + A, has_rd ? R + s : 0);
    sv = '{cfg_rp, cfg_ras, cfg_cas, cfg_cp, cfg_rtw, cfg_wtr};
    sl = '{cfg_lat_cop, cfg_lat_gen};

    @(negedge clk);
    seed = seed * 32'd1664525 + 32'd1013904223;
    dram_dq_in = seed;
    chk("R10", "ready before request", 32'(req_ready), 32'd1);
    req_op = 2'(op); req_bank = bank[0]; req_cop = cop[0];
    req_row = row; req_col_a = ca; req_col_b = cb; req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    for (int n = 0; n < tend + 2; n++) begin
      @(negedge clk);
      if (n == 0) req_valid = 1'b0;
      seed = seed * 32'd1664525 + 32'd1013904223;
      dram_dq_in = seed;
      dval[n] = seed;
      e_ras  = (n >= P && n < tend) ? (bank != 0 ? 2'b01 : 2'b10) : 2'b11;
      if (n >= tend)                 e_addr = '0;
      else if (n < P + 2)            e_addr = row;
      else if (pair && n >= r1)      e_addr = cb;
      else                           e_addr = ca;
      e_cas  = (n >= c1 && n < r1) || (pair && n >= c2 && n < r2);
      e_we   = (fwr && n >= c1 - 1 && n < r1) || (pair && swr && n >= c2 - 1 && n < r2);
      e_oe   = (!fwr && n >= P + 2 && n < r1) || (pair && !swr && n >= r1 && n < r2);
      e_done = (n >= tend && n < tend + 2);
      e_rd   = (has_rd && n >= R + s) ? dval[R + s - 1] : prev_rd;
      chk({tag, " R3"}, "ras_n", 32'(dram_ras_n), 32'(e_ras));
      chk({tag, pair ? " R6" : " R4"}, "addr", 32'(dram_addr), 32'(e_addr));
      chk({tag, pair ? " R6" : " R4"}, "cas_n", 32'(dram_cas_n), 32'(!e_cas));
      chk({tag, " R5"}, "we_n", 32'(dram_we_n), 32'(!e_we));
      chk({tag, " R5"}, "oe_n", 32'(dram_oe_n), 32'(!e_oe));
      chk({tag, " R5"}, "dq_oe", 32'(dram_dq_oe), 32'(e_we));
      if (e_we) chk({tag, " R5"}, "dq_out", dram_dq_out, wd);
      chk({tag, " R7"}, "done", 32'(done), 32'(e_done));
      chk({tag, " R10"}, "ready busy", 32'(req_ready), 32'd0);
      chk({tag, has_rd ? " R8" : " R9"}, "rd_data", rd_data, e_rd);
      if (n == 2) set_cfg(15, 0, 15, 0, 15, 0, 3 - int'(cfg_lat_cop), 3 - int'(cfg_lat_gen));
      if (n == 3) begin req_valid = 1'b1; req_row = ~row; end
      if (n == 4) req_valid = 1'b0;
      if (n == tend + 1) begin
        prev_rd = e_rd;
        {cfg_rp, cfg_ras, cfg_cas, cfg_cp, cfg_rtw, cfg_wtr} = {sv[0], sv[1], sv[2], sv[3], sv[4], sv[5]};
        {cfg_lat_cop, cfg_lat_gen} = {sl[0], sl[1]};
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bank = 1'b0; req_cop = 1'b0;
    req_row = '0; req_col_a = '0; req_col_b = '0; req_wdata = '0; dram_dq_in = '0;
    set_cfg(5, 5, 1, 2, 2, 2, 3, 0);
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1", "ras_n in reset", 32'(dram_ras_n), 32'h3);
    chk("R1", "done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "ras_n idle", 32'(dram_ras_n), 32'h3);
    chk("R1", "cas_n idle", 32'(dram_cas_n), 32'd1);
    chk("R1", "we_n idle", 32'(dram_we_n), 32'd1);
    chk("R1", "oe_n idle", 32'(dram_oe_n), 32'd1);
    chk("R1", "ready idle", 32'(req_ready), 32'd1);
    chk("R1", "addr idle", 32'(dram_addr), 32'd0);

    run(0, 0, 0, 9'h0A5, 9'h013, 9'h000, 32'h0, "rd-min");
    run(0, 1, 1, 9'h1FF, 9'h100, 9'h000, 32'h0, "rd-cop-s3-R8");
    run(1, 0, 0, 9'h055, 9'h0AA, 9'h000, 32'hDEAD_BEEF, "wr-R9");
    set_cfg(0, 0, 0, 0, 0, 0, 1, 2);
    run(2, 0, 0, 9'h123, 9'h045, 9'h067, 32'hCAFE_0001, "rdwr-lo-R2");
    set_cfg(15, 15, 15, 15, 15, 15, 0, 3);
    run(3, 1, 0, 9'h0F0, 9'h00F, 9'h1E1, 32'hCAFE_0002, "wrrd-hi-R2");
    for (int k = 0; k < 4; k++) begin
      set_cfg(6, 8, 2, 3, 4, 3, 3 - k, k);
      run(0, k % 2, 0, 9'(k * 37), 9'(k * 11 + 1), 9'h0, 32'h0, "rd-sel");
      run(0, k % 2, 1, 9'(k * 53), 9'(k * 7 + 2), 9'h0, 32'h0, "rd-cop-sel");
    end
    set_cfg(7, 6, 1, 2, 4, 3, 2, 1);
    run(2, 1, 1, 9'h101, 9'h011, 9'h022, 32'h0BAD_F00D, "rdwr-R6");
    run(3, 0, 1, 9'h102, 9'h033, 9'h044, 32'h1357_9BDF, "wrrd-R6");
    set_cfg(5, 8, 1, 2, 2, 2, 0, 0);
    run(1, 1, 0, 9'h1AB, 9'h0CD, 9'h0, 32'h2468_ACE0, "wr-ras-R7");
    run(0, 0, 0, 9'h1AC, 9'h0CE, 9'h0, 32'h0, "rd-ras-R7");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL R7 watchdog actual=busy expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule